// File: doc/BRIEF.md
# Prefetching Input Stream Buffer

This block sits between main memory and a streaming accelerator. It keeps a short queue of memory bursts, each 64 bytes, and hands them to the accelerator in address order. A host-side load names one burst by its byte address. If that burst is already at the front of the queue, nothing is fetched. Any other load discards the whole queue. It then starts a fresh run: the named burst followed by as many consecutive bursts as fit. A run holds at most 16 bursts and never passes the end of the 4 KB page that contains the named burst.

Every memory request carries a tag. The tag holds the slot the burst lands in and a run counter, the epoch. A response whose epoch belongs to an abandoned run is dropped. The accelerator sees the front burst only after its data has arrived, and it takes that burst with a valid/ready handshake.

Top module: `sbuf_prefetch`

## Requirements
- R1: After reset the queue is empty: `out_valid` and `mem_req_valid` are both low until a load arrives.
- R2: A load that misses starts a run. The first request is for the named burst, and each following request is 64 bytes higher. A run has at most 16 requests.
- R3: A run never leaves the 4 KB page of the named burst. Its length is the smaller of 16 and the number of bursts from the named burst to the end of the page.
- R4: A load whose burst address equals the front burst is a hit, even if that burst's data has not yet arrived. A hit issues no memory request and leaves the queue contents unchanged.
- R5: Loads are compared on the burst address only. Address bits [5:0] are ignored.
- R6: A load is a miss when the queue is empty or when the load matches only an entry behind the front. A miss invalidates every entry, so `out_valid` is low in the cycle after the miss.
- R7: A memory response whose tag epoch differs from the current run is discarded. Its data never reaches `out_data`.
- R8: `out_valid` is high only when the front burst's data has arrived. `out_addr` is that burst's byte address, and `out_data` is the data returned for it.
- R9: Bursts leave in ascending address order, one per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_addr` stays unchanged.
- R10: While `mem_req_ready` is low, a pending memory request keeps `mem_req_valid` high and `mem_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load request strobe, one cycle per load |
| ld_addr | input | ADDR_W | Byte address of the requested burst |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Burst-aligned read address |
| mem_req_tag | output | EPOCH_W+log2(DEPTH) | Tag: epoch in the upper bits, slot in the lower bits |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_tag | input | EPOCH_W+log2(DEPTH) | Tag echoed from the request |
| mem_rsp_data | input | BURST_BYTES*8 | Burst data |
| out_valid | output | 1 | Front burst is available to the accelerator |
| out_ready | input | 1 | Accelerator takes the front burst |
| out_addr | output | ADDR_W | Byte address of the front burst |
| out_data | output | BURST_BYTES*8 | Data of the front burst |

## Verification
A load is sampled at one clock edge, and the first request of its run is visible in the following cycle. Each response lands in its slot at the edge where it is presented, so a response becomes visible at the output one cycle later. The flush caused by a miss is visible one cycle after the load. The bench drives its inputs just after each rising edge and samples outputs at the falling edge. It clears and refills its expected request and output queues in the cycle after the load edge, so the bursts it compares always belong to the run that is active at that point. The memory model answers each accepted request a fixed four cycles later. This makes stale responses from an abandoned run arrive after the flush that should drop them.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   // Length of a prefetch run: bounded by queue depth and by the bursts
   // left between the starting burst and the end of its page.
   function automatic int run_len(input int page_off, input int page_bursts, input int depth);
      int room;
      room = page_bursts - page_off;
      return (room < depth) ? room : depth;
   endfunction

endpackage

// File: rtl/sbuf_pf_gen.sv
module sbuf_pf_gen #(
   parameter int BA_W  = 26,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BA_W-1:0]  start_burst,
   input  logic [CNT_W-1:0] start_len,
   input  logic             req_ready,
   output logic             req_valid,
   output logic [BA_W-1:0]  req_burst,
   output logic [IDX_W-1:0] req_idx,
   output logic [BA_W-1:0]  run_base,
   output logic [CNT_W-1:0] run_len
);

   logic [CNT_W-1:0] issued;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_base <= '0;
         run_len  <= '0;
         issued   <= '0;
      end else if (start) begin
         run_base <= start_burst;
         run_len  <= start_len;
         issued   <= '0;
      end else if (req_valid && req_ready) begin
         issued   <= issued + 1'b1;
      end
   end

   assign req_valid = issued < run_len;
   assign req_burst = run_base + BA_W'(issued);
   assign req_idx   = issued[IDX_W-1:0];

endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 512,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              pop,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  hd,
   output logic              head_vld,
   output logic [DATA_W-1:0] head_data
);

   logic [DEPTH-1:0]  vld;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n)     hd <= '0;
      else if (flush) hd <= '0;
      else if (pop)   hd <= hd + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                          vld[i] <= 1'b0;
         else if (flush)                      vld[i] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(i)) vld[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign head_vld  = (hd < CNT_W'(DEPTH)) ? vld[hd[IDX_W-1:0]] : 1'b0;
   assign head_data = mem[hd[IDX_W-1:0]];

endmodule

// File: rtl/sbuf_prefetch.sv
module sbuf_prefetch #(
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 64,
   parameter int DEPTH       = 16,
   parameter int PAGE_BYTES  = 4096,
   parameter int EPOCH_W     = 3,
   localparam int DATA_W     = BURST_BYTES * 8,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int TAG_W      = EPOCH_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [TAG_W-1:0]  mem_req_tag,
   input  logic              mem_rsp_valid,
   input  logic [TAG_W-1:0]  mem_rsp_tag,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);

   localparam int BOFF_W    = $clog2(BURST_BYTES);
   localparam int BA_W      = ADDR_W - BOFF_W;
   localparam int CNT_W     = IDX_W + 1;
   localparam int PG_BURSTS = PAGE_BYTES / BURST_BYTES;
   localparam int PG_W      = $clog2(PG_BURSTS);

   // elaboration-time parameter checks
   if ((BURST_BYTES & (BURST_BYTES - 1)) != 0 || BURST_BYTES < 2) begin : g_bad_burst
      $error("BURST_BYTES must be a power of two");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 * BURST_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two holding at least two bursts");
   end
   if (EPOCH_W < 2) begin : g_bad_epoch
      $error("EPOCH_W must be at least 2");
   end

   logic [BA_W-1:0]    ld_burst, head_burst, run_base, req_burst;
   logic [CNT_W-1:0]   run_len, hd, miss_len;
   logic [IDX_W-1:0]   req_idx;
   logic [EPOCH_W-1:0] epoch;
   logic               is_empty, is_hit, do_miss, rsp_ok, head_vld, pop;
   logic               unused_low;

   assign ld_burst   = ld_addr[ADDR_W-1:BOFF_W];
   assign unused_low = ^ld_addr[BOFF_W-1:0];
   assign head_burst = run_base + BA_W'(hd);
   assign is_empty   = hd >= run_len;
   assign is_hit     = !is_empty && (ld_burst == head_burst);
   assign do_miss    = ld_valid && !is_hit;
   assign miss_len   = CNT_W'(sbuf_pkg::run_len(int'(ld_burst[PG_W-1:0]), PG_BURSTS, DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n)       epoch <= '0;
      else if (do_miss) epoch <= epoch + 1'b1;
   end

   assign rsp_ok = mem_rsp_valid && !do_miss && (mem_rsp_tag[TAG_W-1:IDX_W] == epoch);
   assign pop    = out_valid && out_ready;

   sbuf_pf_gen #(.BA_W(BA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (do_miss),
      .start_burst(ld_burst),
      .start_len  (miss_len),
      .req_ready  (mem_req_ready),
      .req_valid  (mem_req_valid),
      .req_burst  (req_burst),
      .req_idx    (req_idx),
      .run_base   (run_base),
      .run_len    (run_len)
   );

   sbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (do_miss),
      .pop      (pop),
      .wr_en    (rsp_ok),
      .wr_idx   (mem_rsp_tag[IDX_W-1:0]),
      .wr_data  (mem_rsp_data),
      .hd       (hd),
      .head_vld (head_vld),
      .head_data(out_data)
   );

   assign mem_req_addr = {req_burst, {BOFF_W{1'b0}}};
   assign mem_req_tag  = {epoch, req_idx};
   assign out_valid    = !is_empty && head_vld;
   assign out_addr     = {head_burst, {BOFF_W{1'b0}}};

endmodule

// File: rtl/sbuf_prefetch_chk.sv
module sbuf_prefetch_chk #(
   parameter int ADDR_W = 32,
   parameter int BOFF_W = 6,
   parameter int PG_W   = 6,
   parameter int CNT_W  = 5,
   parameter int DEPTH  = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ld_valid,
   input logic [ADDR_W-1:0]        ld_addr,
   input logic                     mem_req_valid,
   input logic                     mem_req_ready,
   input logic [ADDR_W-1:0]        mem_req_addr,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [ADDR_W-1:0]        out_addr,
   input logic [ADDR_W-BOFF_W-1:0] run_base,
   input logic [CNT_W-1:0]         run_len,
   input logic [CNT_W-1:0]         hd
);

   logic front_match;
   assign front_match = (hd < run_len) &&
                        (ld_addr[ADDR_W-1:BOFF_W] == run_base + (ADDR_W-BOFF_W)'(hd));

   // R1
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && !mem_req_valid);

   // R2
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= CNT_W'(DEPTH));

   // R3
   page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[ADDR_W-1:BOFF_W+PG_W] == run_base[ADDR_W-BOFF_W-1:PG_W]);

   // R4
   hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && front_match |=> $stable(run_base) && $stable(run_len));

   // R6
   miss_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && !front_match |=> !out_valid && hd == '0);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !ld_valid |=> out_valid && $stable(out_addr));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready && !ld_valid |=> mem_req_valid && $stable(mem_req_addr));

endmodule

bind sbuf_prefetch sbuf_prefetch_chk #(
   .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .PG_W(PG_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_valid     (ld_valid),
   .ld_addr      (ld_addr),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_addr     (out_addr),
   .run_base     (run_base),
   .run_len      (run_len),
   .hd           (hd)
);

// File: tb/sim_sbuf_prefetch.sv
module sim_sbuf_prefetch;
   localparam int AW  = 32;
   localparam int DW  = 512;
   localparam int TW  = 7;
   localparam int LAT = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, ld_valid, mem_req_valid, mem_req_ready, mem_rsp_valid, out_valid, out_ready;
   logic [AW-1:0] ld_addr, mem_req_addr, out_addr;
   logic [TW-1:0] mem_req_tag, mem_rsp_tag;
   logic [DW-1:0] mem_rsp_data, out_data;

   sbuf_prefetch u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int run_req_cnt = 0, pop_cnt = 0, rdy_mode = 0, mrdy_mode = 0;
   bit done = 0;
   logic [AW-1:0] exp_req[$];
   logic [AW-1:0] exp_out[$];
   int            rq_due[$];
   logic [TW-1:0] rq_tag[$];
   logic [AW-1:0] rq_addr[$];

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {16{a}};
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // input driver: ready patterns and memory responder, just after each edge
   initial begin
      out_ready = 1'b0; mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0; mem_rsp_tag = '0; mem_rsp_data = '0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         out_ready     = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
         mem_req_ready = (mrdy_mode == 0) ? 1'b1 : (mrdy_mode == 1) ? cyc[0] : 1'b0;
         if (rq_due.size() > 0 && rq_due[0] == cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_tag   = rq_tag.pop_front();
            mem_rsp_data  = pat(rq_addr.pop_front());
            void'(rq_due.pop_front());
         end else begin
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // monitor: compares requests and delivered bursts with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mem_req_valid && mem_req_ready) begin
               run_req_cnt++;
               if (exp_req.size() == 0) check(1'b0, "R3", "unexpected request", mem_req_addr, '0);
               else begin
                  check(mem_req_addr == exp_req[0], "R2", "request address", mem_req_addr, exp_req[0]);
                  void'(exp_req.pop_front());
               end
               rq_due.push_back(cyc + LAT);
               rq_tag.push_back(mem_req_tag);
               rq_addr.push_back(mem_req_addr);
            end
            if (out_valid && out_ready) begin
               pop_cnt++;
               if (exp_out.size() == 0) check(1'b0, "R8", "unexpected burst", out_addr, '0);
               else begin
                  check(out_addr == exp_out[0], "R9", "burst order", out_addr, exp_out[0]);
                  check(out_data == pat(exp_out[0]), "R7", "burst data", out_data[AW-1:0], exp_out[0]);
                  void'(exp_out.pop_front());
               end
            end
         end
      end
   end

   task automatic do_load(input logic [AW-1:0] a, input bit miss, input int n);
      @(posedge clk); #1;
      ld_valid = 1'b1; ld_addr = a;
      @(posedge clk); #1;
      ld_valid = 1'b0;
      if (miss) begin
         exp_req.delete(); exp_out.delete();
         for (int i = 0; i < n; i++) begin
            exp_req.push_back({a[AW-1:6], 6'b0} + AW'(i * 64));
            exp_out.push_back({a[AW-1:6], 6'b0} + AW'(i * 64));
         end
         run_req_cnt = 0; pop_cnt = 0;
      end
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 2000 && (exp_req.size() != 0 || exp_out.size() != 0); i++) @(posedge clk);
      repeat (LAT + 4) @(posedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int snap;
      rst_n = 1'b0; ld_valid = 1'b0; ld_addr = '0;
      repeat (5) @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R1", "out_valid after reset", AW'(out_valid), 0);
      check(!mem_req_valid, "R1", "mem_req_valid after reset", AW'(mem_req_valid), 0);

      // full run from a page start into an empty queue (R2, R6)
      do_load(32'h0001_0000, 1, 16);
      wait_drain();
      check(run_req_cnt == 16, "R2", "run length at page start", AW'(run_req_cnt), 16);
      check(pop_cnt == 16, "R9", "bursts delivered", AW'(pop_cnt), 16);

      // run clipped at page end, memory throttled (R3)
      mrdy_mode = 1;
      do_load(32'h0002_0F40, 1, 3);
      wait_drain();
      check(run_req_cnt == 3, "R3", "run clipped at page end", AW'(run_req_cnt), 3);
      check(pop_cnt == 3, "R3", "clipped bursts delivered", AW'(pop_cnt), 3);
      mrdy_mode = 0;

      // hit on front, low bits ignored, then a miss on a deeper entry
      rdy_mode = 2;
      do_load(32'h0003_0000, 1, 16);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(out_valid, "R8", "front valid once data is back", AW'(out_valid), 1);
      check(out_addr == 32'h0003_0000, "R8", "front address", out_addr, 32'h0003_0000);
      snap = run_req_cnt;
      do_load(32'h0003_0005, 0, 0);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(run_req_cnt == snap, "R4", "no fetch on hit", AW'(run_req_cnt), AW'(snap));
      check(out_valid && out_addr == 32'h0003_0000, "R5", "front kept after low-bit hit",
            out_addr, 32'h0003_0000);
      do_load(32'h0003_0040, 1, 16);
      @(negedge clk);
      check(!out_valid, "R6", "flush after non-front match", AW'(out_valid), 0);
      rdy_mode = 0;
      wait_drain();
      check(pop_cnt == 16, "R6", "new run delivered", AW'(pop_cnt), 16);

      // back-to-back misses: old responses must be dropped (R7)
      rdy_mode = 1;
      do_load(32'h0004_0000, 1, 16);
      @(posedge clk);
      do_load(32'h0005_0000, 1, 16);
      wait_drain();
      check(pop_cnt == 16, "R7", "only current run delivered", AW'(pop_cnt), 16);
      rdy_mode = 0;

      // memory stalled: request held, no output without data (R10, R8)
      mrdy_mode = 2;
      do_load(32'h0006_0080, 1, 16);
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == 32'h0006_0080, "R10", "request held under stall",
            mem_req_addr, 32'h0006_0080);
      check(!out_valid, "R8", "no output before data", AW'(out_valid), 0);
      mrdy_mode = 0;
      wait_drain();
      check(pop_cnt == 16, "R10", "run completes after stall", AW'(pop_cnt), 16);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule